// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block decides, once per completed instruction, whether a small 8-bit CPU core should be diverted to an interrupt handler, and which one. Five maskable sources feed it: external request 0, timer 0 overflow, external request 1, timer 1 overflow and a serial port whose request is the OR of its receive-done and transmit-done flags. Each source has its own enable and its own level bit, so it sits at either the high or the low level. Within a level, a fixed polling order breaks ties.

The controller keeps one in-service flag per level. A low-level handler can be interrupted by a high-level request, but not by another low-level one. A running high-level handler blocks everything. When a request is granted, the block pulses a one-hot acknowledge and latches the handler's vector address. It also pulses a clear for the timer flags and for edge-mode external flags. The CPU's return-from-interrupt strobe closes the most recent handler level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the acknowledge, flag-clear and both in-service outputs are zero, and the vector output is 0x0000.
- R2: A source is eligible only when its flag, its own enable bit and the global enable bit are all 1. The enable bits are bit 0 for external 0, bit 1 for timer 0, bit 2 for external 1, bit 3 for timer 1 and bit 4 for serial, and bit 5 is the global enable.
- R3: A grant happens only in a cycle where `instr_end` is 1. Its acknowledge appears in the following cycle, and pending requests without the strobe produce no acknowledge.
- R4: Among eligible requests at the same level, the source earliest in the order external 0, timer 0, external 1, timer 1, serial wins.
- R5: Level bits use the same positions as R2, with 1 meaning high. An eligible high-level request wins over every low-level one. With only bit 4 set, serial outranks the rest, and the others keep their polling order.
- R6: `irq_ack` is one-hot, with bit i for the source at polling position i. On a grant, `irq_vector` becomes 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 for polling positions 0 to 4, and it holds its value between grants.
- R7: While a low-level handler is in service, no low-level request is granted, but a high-level one is, and both in-service flags are then 1.
- R8: While a high-level handler is in service, no request is granted.
- R9: A `ret_intr` pulse clears the high in-service flag if it is set, and otherwise clears the low one.
- R10: The serial request is the OR of `ser_rx_done` and `ser_tx_done`, and a serial grant pulses no flag clear. A timer grant always pulses its `flag_clr` bit. An external grant pulses its `flag_clr` bit only when its `ext_edge_mode` bit is 1. The `flag_clr` bits are 0 for external 0, 1 for timer 0, 2 for external 1 and 3 for timer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | 4 | Request flags: external 0, timer 0, external 1, timer 1 |
| ser_rx_done | input | 1 | Serial receive-complete flag |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| ext_edge_mode | input | 2 | Edge mode of external 0 (bit 0) and external 1 (bit 1) |
| irq_en | input | 6 | Per-source enables, global enable in bit 5 |
| irq_prio | input | 5 | Per-source level bit, 1 = high |
| instr_end | input | 1 | Instruction-boundary strobe |
| ret_intr | input | 1 | Return-from-interrupt strobe |
| irq_ack | output | 5 | One-cycle one-hot grant pulse |
| irq_vector | output | 16 | Handler address of the last grant |
| flag_clr | output | 4 | One-cycle clear pulse for the hardware-cleared flags |
| svc_high | output | 1 | High-level handler in service |
| svc_low | output | 1 | Low-level handler in service |

## Verification
Several sources are raised together with all level bits at zero, which checks that polling order alone picks the winner. The same mixes are then repeated with a single level bit set on a late source, which shows that the level overrides position. Requests are also raised with the boundary strobe low, with the global enable off, and with only the source's own enable off, which separates the three gating conditions. A request arriving during a low-level handler is tried at both levels, and return strobes are issued with both handler levels active, which shows which in-service flag each one closes. Serial grants are made through each of its two flags, and external grants are made with edge mode on and off, which shows exactly which flags get a clear pulse.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC      = 5;                 // maskable sources
  localparam int IDXW      = $clog2(NSRC);
  localparam int NHWCLR    = 4;                 // sources with hardware-cleared flags
  localparam int NLVL      = 2;                 // priority levels
  localparam int VECW      = 16;
  localparam int VEC_BASE  = 3;
  localparam int VEC_STEP  = 8;
  localparam int ENW       = NSRC + 1;          // per-source enables plus global
  localparam int GLB_BIT   = NSRC;

  typedef enum logic [IDXW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    return VECW'(VEC_BASE) + VECW'(idx) * VECW'(VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_prio_pkg::*;
(
  input  logic [NSRC-1:0] raw,
  input  logic [ENW-1:0]  en,
  output logic [NSRC-1:0] pend
);
  always_comb begin
    pend = raw & en[NSRC-1:0] & {NSRC{en[GLB_BIT]}};
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_chain
    assign onehot[gi]   = req[gi] & ~seen[gi];
    assign seen[gi + 1] = seen[gi] | req[gi];
  end

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/irq_svc.sv
module irq_svc (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_hi,
  input  logic grant_lo,
  input  logic reti,
  output logic svc_hi,
  output logic svc_lo
);
  logic hi_n, lo_n, upd;

  always_comb begin
    hi_n = svc_hi;
    lo_n = svc_lo;
    if (reti) begin
      if (svc_hi) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (grant_hi) hi_n = 1'b1;
    if (grant_lo) lo_n = 1'b1;
    upd = reti | grant_hi | grant_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else if (upd) begin
      svc_hi <= hi_n;
      svc_lo <= lo_n;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NHWCLR-1:0] src_flag,
  input  logic              ser_rx_done,
  input  logic              ser_tx_done,
  input  logic [1:0]        ext_edge_mode,
  input  logic [ENW-1:0]    irq_en,
  input  logic [NSRC-1:0]   irq_prio,
  input  logic              instr_end,
  input  logic              ret_intr,
  output logic [NSRC-1:0]   irq_ack,
  output logic [VECW-1:0]   irq_vector,
  output logic [NHWCLR-1:0] flag_clr,
  output logic              svc_high,
  output logic              svc_low
);
  logic [NSRC-1:0]           raw, pend;
  logic [NLVL-1:0][NSRC-1:0] lvl_req, lvl_oh;
  logic [NLVL-1:0][IDXW-1:0] lvl_idx;
  logic [NLVL-1:0]           lvl_found;
  logic                      grant_hi, grant_lo, grant_any;
  logic [NSRC-1:0]           win_oh, ack_n;
  logic [IDXW-1:0]           win_idx;
  logic [VECW-1:0]           vec_n;
  logic [NHWCLR-1:0]         clr_n;

  assign raw = {ser_rx_done | ser_tx_done, src_flag};

  irq_gate u_gate (.raw(raw), .en(irq_en), .pend(pend));

  assign lvl_req[0] = pend & ~irq_prio;
  assign lvl_req[1] = pend &  irq_prio;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    irq_pick #(.N(NSRC), .IW(IDXW)) u_pick (
      .req    (lvl_req[l]),
      .found  (lvl_found[l]),
      .onehot (lvl_oh[l]),
      .idx    (lvl_idx[l])
    );
  end

  irq_svc u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_hi (grant_hi),
    .grant_lo (grant_lo),
    .reti     (ret_intr),
    .svc_hi   (svc_high),
    .svc_lo   (svc_low)
  );

  always_comb begin
    grant_hi  = instr_end & lvl_found[1] & ~svc_high;
    grant_lo  = instr_end & ~grant_hi & lvl_found[0] & ~svc_high & ~svc_low;
    grant_any = grant_hi | grant_lo;
    win_oh    = grant_hi ? lvl_oh[1]  : (grant_lo ? lvl_oh[0] : '0);
    win_idx   = grant_hi ? lvl_idx[1] : lvl_idx[0];
    ack_n     = win_oh;
    vec_n     = grant_any ? vec_of(win_idx) : irq_vector;
  end

  for (genvar j = 0; j < NHWCLR; j++) begin : g_clr
    if (j % 2 == 0) begin : g_ext
      assign clr_n[j] = win_oh[j] & ext_edge_mode[j / 2];
    end else begin : g_tmr
      assign clr_n[j] = win_oh[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_ack    <= '0;
      flag_clr   <= '0;
      irq_vector <= '0;
    end else begin
      irq_ack  <= ack_n;
      flag_clr <= clr_n;
      if (grant_any) irq_vector <= vec_n;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ENW-1:0]    irq_en,
  input logic              instr_end,
  input logic              ret_intr,
  input logic [NSRC-1:0]   irq_ack,
  input logic [VECW-1:0]   irq_vector,
  input logic [NHWCLR-1:0] flag_clr,
  input logic              svc_high,
  input logic              svc_low
);
  p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> $past(irq_en[GLB_BIT]));

  p_ack_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> $past(instr_end));

  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_ack) |-> $stable(irq_vector));

  p_low_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|irq_ack) && $past(svc_low)) |-> svc_high);

  p_high_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> !$past(svc_high));

  p_reti_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_intr) && !$past(instr_end) && $past(svc_high))
      |-> (!svc_high && (svc_low == $past(svc_low))));

  p_clr_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr & ~irq_ack[NHWCLR-1:0]) == '0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_en     (irq_en),
  .instr_end  (instr_end),
  .ret_intr   (ret_intr),
  .irq_ack    (irq_ack),
  .irq_vector (irq_vector),
  .flag_clr   (flag_clr),
  .svc_high   (svc_high),
  .svc_low    (svc_low)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_flag = '0;
  logic        ser_rx_done = 1'b0, ser_tx_done = 1'b0;
  logic [1:0]  ext_edge_mode = '0;
  logic [5:0]  irq_en = '0;
  logic [4:0]  irq_prio = '0;
  logic        instr_end = 1'b0, ret_intr = 1'b0;
  logic [4:0]  irq_ack;
  logic [15:0] irq_vector;
  logic [3:0]  flag_clr;
  logic        svc_high, svc_low;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [4:0]  ack;
    logic [15:0] vec;
    logic [3:0]  clr;
    logic        hi;
    logic        lo;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  irq_prio_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] f, input logic rx, input logic tx,
                      input logic [1:0] edg, input logic [5:0] en, input logic [4:0] pr,
                      input logic idn, input logic rt,
                      input logic [4:0] eack, input logic [15:0] evec,
                      input logic [3:0] eclr, input logic ehi, input logic elo,
                      input string tag);
    exp_t e;
    @(negedge clk);
    src_flag = f; ser_rx_done = rx; ser_tx_done = tx; ext_edge_mode = edg;
    irq_en = en; irq_prio = pr; instr_end = idn; ret_intr = rt;
    e.ack = eack; e.vec = evec; e.clr = eclr; e.hi = ehi; e.lo = elo; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares outputs registered at the edge after each driven step
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(irq_ack == e.ack, e.tag, "ack", 16'(irq_ack), 16'(e.ack));
        chk(irq_vector == e.vec, e.tag, "vector", irq_vector, e.vec);
        chk(flag_clr == e.clr, e.tag, "flag_clr", 16'(flag_clr), 16'(e.clr));
        chk(svc_high == e.hi, e.tag, "svc_high", 16'(svc_high), 16'(e.hi));
        chk(svc_low == e.lo, e.tag, "svc_low", 16'(svc_low), 16'(e.lo));
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: reset state
    chk(irq_ack == 0 && flag_clr == 0 && !svc_high && !svc_low, "R1", "outputs",
        {irq_ack, flag_clr, svc_high, svc_low, 5'd0}, 16'd0);
    chk(irq_vector == 16'h0000, "R1", "vector", irq_vector, 16'h0000);

    //    flags   rx tx  edge   en     prio   idn rt  ack       vec      clr      hi lo
    step(4'b0001, 0, 0, 2'b01, 6'h21, 5'h00, 0, 0, 5'b00000, 16'h0000, 4'b0000, 0, 0, "R3 no strobe");
    step(4'b0001, 0, 0, 2'b01, 6'h21, 5'h00, 1, 0, 5'b00001, 16'h0003, 4'b0001, 0, 1, "R3 R6 R10 ext0 edge");
    step(4'b0000, 0, 0, 2'b01, 6'h21, 5'h00, 0, 1, 5'b00000, 16'h0003, 4'b0000, 0, 0, "R9 close low");
    step(4'b1111, 1, 0, 2'b00, 6'h1F, 5'h00, 1, 0, 5'b00000, 16'h0003, 4'b0000, 0, 0, "R2 global off");
    step(4'b0001, 0, 0, 2'b00, 6'h3E, 5'h00, 1, 0, 5'b00000, 16'h0003, 4'b0000, 0, 0, "R2 own enable off");
    step(4'b1110, 0, 0, 2'b00, 6'h3F, 5'h00, 1, 0, 5'b00010, 16'h000B, 4'b0010, 0, 1, "R4 poll tmr0");
    step(4'b0001, 0, 0, 2'b00, 6'h3F, 5'h00, 1, 0, 5'b00000, 16'h000B, 4'b0000, 0, 1, "R7 low blocks low");
    step(4'b0001, 1, 0, 2'b00, 6'h3F, 5'h10, 1, 0, 5'b10000, 16'h0023, 4'b0000, 1, 1, "R5 R7 serial preempts");
    step(4'b0001, 0, 0, 2'b00, 6'h3F, 5'h01, 1, 0, 5'b00000, 16'h0023, 4'b0000, 1, 1, "R8 high blocks");
    step(4'b0000, 0, 0, 2'b00, 6'h3F, 5'h00, 0, 1, 5'b00000, 16'h0023, 4'b0000, 0, 1, "R9 high first");
    step(4'b0000, 0, 0, 2'b00, 6'h3F, 5'h00, 0, 1, 5'b00000, 16'h0023, 4'b0000, 0, 0, "R9 then low");
    step(4'b1100, 0, 1, 2'b00, 6'h3F, 5'h10, 1, 0, 5'b10000, 16'h0023, 4'b0000, 1, 0, "R10 tx serial no clr");
    step(4'b0000, 0, 0, 2'b00, 6'h3F, 5'h10, 0, 1, 5'b00000, 16'h0023, 4'b0000, 0, 0, "R9 close high");
    step(4'b1100, 0, 0, 2'b00, 6'h3F, 5'h10, 1, 0, 5'b00100, 16'h0013, 4'b0000, 0, 1, "R4 R5 R10 ext1 level");
    step(4'b0000, 0, 0, 2'b00, 6'h3F, 5'h10, 0, 1, 5'b00000, 16'h0013, 4'b0000, 0, 0, "R9 close low");
    step(4'b1001, 0, 0, 2'b11, 6'h3F, 5'h08, 1, 0, 5'b01000, 16'h001B, 4'b1000, 1, 0, "R5 tmr1 high");
    step(4'b0000, 0, 0, 2'b11, 6'h3F, 5'h08, 0, 1, 5'b00000, 16'h001B, 4'b0000, 0, 0, "R9 close high");
    step(4'b0100, 0, 0, 2'b10, 6'h3F, 5'h00, 1, 0, 5'b00100, 16'h0013, 4'b0100, 0, 1, "R10 ext1 edge clr");
    step(4'b0000, 0, 0, 2'b10, 6'h3F, 5'h00, 0, 1, 5'b00000, 16'h0013, 4'b0000, 0, 0, "R9 close low");

    @(negedge clk);
    instr_end = 1'b0; ret_intr = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule